// File: doc/BRIEF.md
# Snoop-Invalidating Data Cache

This block is a small direct-mapped data cache placed between a processor load/store port and a local RAM. Each line holds one data word with a tag, a valid bit and a dirty bit. The top address bits select an entry in a region table supplied on an input port. That entry sets the policy for the address: no caching, write-through, or write-back. Both cached policies can be active at the same time, each over its own slice of the same RAM.

A second bus master writes the RAM directly through its own port. It reports each written word address to the cache on a one-cycle notification input. When that address lies in a write-through region and matches a valid line, the cache drops the line. The cache never takes data from the notification. Write-back regions get no such protection. Software keeps them coherent with per-address maintenance commands: clean, invalidate, or both together. A single memory-side request port serves line fills, victim write-backs and uncached traffic. It holds each request until the RAM acknowledges it.

Top module: `coh_dcache`

## Requirements
- R1: After reset, no line is valid and `cpu_ack`, `mnt_ack` and `mem_req` are low. The first cacheable read of any address therefore makes one RAM read.
- R2: The region is `addr[7:6]`. Its policy is `region_pol[2*r+1:2*r]`, where 00 and 11 mean non-cacheable, 01 means write-through and 10 means write-back. Every non-cacheable read or write makes exactly one RAM access and allocates no line.
- R3: A write-through write always makes one RAM write. A hit also updates the line. A miss allocates nothing.
- R4: A write-back write marks the line dirty and makes no RAM write to that address. On a hit it updates the line. On a miss it allocates the line without a fill.
- R5: A cacheable read miss makes one RAM read, returns that word and installs it. A later read of the same address hits and makes no RAM access.
- R6: When a read miss would replace a dirty line, the dirty word is first written to RAM at its own address, and only then is the fill read made.
- R7: A notification whose address is in a write-through region and hits a valid line invalidates that line. The next read of that address fetches the current RAM word.
- R8: A notification whose address is in a write-back region changes nothing. The next read still returns the cached word.
- R9: Maintenance op 01 (clean) writes a dirty matching line to RAM and keeps it valid. On a clean or missing line it makes no RAM write.
- R10: Maintenance op 10 (invalidate) clears valid and dirty without writing to RAM. Any dirty data in the line is discarded.
- R11: Maintenance op 11 (clean plus invalidate) writes back a dirty matching line and then clears its valid and dirty bits.
- R12: A write-through notification at the same line index as a fill in flight leaves the filled line invalid. The processor still receives the fetched word, and the next read of that address misses.
- R13: When a maintenance command and a processor request are pending together in idle, the maintenance command is served first. Each request gets one single-cycle acknowledge, and the two acknowledges never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| region_pol | input | 8 | Policy per region, two bits each |
| cpu_req | input | 1 | Processor request, held until acknowledged |
| cpu_we | input | 1 | Processor write when high |
| cpu_addr | input | 8 | Processor word address |
| cpu_wdata | input | 32 | Processor write data |
| cpu_ack | output | 1 | One-cycle processor acknowledge |
| cpu_rdata | output | 32 | Read data, valid with the acknowledge |
| mnt_req | input | 1 | Maintenance request, held until acknowledged |
| mnt_op | input | 2 | 01 clean, 10 invalidate, 11 both, 00 no effect |
| mnt_addr | input | 8 | Maintenance word address |
| mnt_ack | output | 1 | One-cycle maintenance acknowledge |
| snp_valid | input | 1 | External master wrote RAM this cycle |
| snp_addr | input | 8 | Word address written by the external master |
| mem_req | output | 1 | RAM request, held until `mem_ack` |
| mem_we | output | 1 | RAM write when high |
| mem_addr | output | 8 | RAM word address |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle RAM acknowledge |

## Verification
Two functions can meet in the same cycle. One is a coherency notification. The other is a fill that is waiting on the RAM at the same line index, or a maintenance command racing a processor request in idle. The bench slows the RAM model to several cycles per access. It starts a read miss, watches the memory port for the fill request, and then pulses a notification for the old line at that index. The collision is judged at the ports. The processor must still receive the fetched word, and the following read of the same address must make a fresh RAM read. For the idle race, both requests are raised in one cycle. The order of the two acknowledges is checked, along with whether the later read reaches RAM.

// File: rtl/coh_dcache_pkg.sv
package coh_dcache_pkg;

    typedef enum logic [1:0] {
        POL_UNCACHED = 2'b00,
        POL_WTHRU    = 2'b01,
        POL_WBACK    = 2'b10,
        POL_UNC_ALT  = 2'b11
    } pol_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_MWR,
        ST_NCRD,
        ST_DONE
    } st_e;

    localparam logic [1:0] OP_CLEAN_BIT = 2'b01;
    localparam logic [1:0] OP_INVAL_BIT = 2'b10;

endpackage

// File: rtl/coh_region_map.sv
module coh_region_map
    import coh_dcache_pkg::*;
#(
    parameter int AW   = 8,
    parameter int RB   = 2
) (
    input  logic [AW-1:0]        addr,
    input  logic [2*(1<<RB)-1:0] pol_tbl,
    output pol_e                 pol
);
    logic [RB-1:0] region;

    always_comb begin
        region = addr[AW-1 -: RB];
        pol    = pol_e'(pol_tbl[2*region +: 2]);
    end
endmodule

// File: rtl/coh_tag_store.sv
module coh_tag_store #(
    parameter int IDX_W = 3,
    parameter int TAG_W = 5,
    parameter int DW    = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IDX_W-1:0]   ra_idx,
    output logic               ra_valid,
    output logic               ra_dirty,
    output logic [TAG_W-1:0]   ra_tag,
    output logic [DW-1:0]      ra_data,
    input  logic [IDX_W-1:0]   rb_idx,
    output logic               rb_valid,
    output logic [TAG_W-1:0]   rb_tag,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [DW-1:0]      wr_data,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [(1<<IDX_W)-1:0] valid_vec,
    output logic [(1<<IDX_W)-1:0] dirty_vec
);
    localparam int NL = 1 << IDX_W;

    logic [NL-1:0]            valid_d, valid_q;
    logic [NL-1:0]            dirty_d, dirty_q;
    logic [NL-1:0][TAG_W-1:0] tag_d, tag_q;
    logic [NL-1:0][DW-1:0]    data_d, data_q;

    always_comb begin
        valid_d = valid_q;
        dirty_d = dirty_q;
        tag_d   = tag_q;
        data_d  = data_q;
        if (clr_en) begin
            valid_d[clr_idx] = 1'b0;
            dirty_d[clr_idx] = 1'b0;
        end
        if (wr_en) begin
            valid_d[wr_idx] = wr_valid;
            dirty_d[wr_idx] = wr_dirty;
            tag_d[wr_idx]   = wr_tag;
            data_d[wr_idx]  = wr_data;
        end
    end

    generate
        for (genvar i = 0; i < NL; i++) begin : g_line
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q[i] <= 1'b0;
                    dirty_q[i] <= 1'b0;
                    tag_q[i]   <= '0;
                    data_q[i]  <= '0;
                end else begin
                    valid_q[i] <= valid_d[i];
                    dirty_q[i] <= dirty_d[i];
                    tag_q[i]   <= tag_d[i];
                    data_q[i]  <= data_d[i];
                end
            end
        end
    endgenerate

    assign ra_valid  = valid_q[ra_idx];
    assign ra_dirty  = dirty_q[ra_idx];
    assign ra_tag    = tag_q[ra_idx];
    assign ra_data   = data_q[ra_idx];
    assign rb_valid  = valid_q[rb_idx];
    assign rb_tag    = tag_q[rb_idx];
    assign valid_vec = valid_q;
    assign dirty_vec = dirty_q;
endmodule

// File: rtl/coh_dcache.sv
module coh_dcache
    import coh_dcache_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 32,
    parameter int IDX_W = 3,
    parameter int RB    = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [2*(1<<RB)-1:0] region_pol,
    input  logic                 cpu_req,
    input  logic                 cpu_we,
    input  logic [AW-1:0]        cpu_addr,
    input  logic [DW-1:0]        cpu_wdata,
    output logic                 cpu_ack,
    output logic [DW-1:0]        cpu_rdata,
    input  logic                 mnt_req,
    input  logic [1:0]           mnt_op,
    input  logic [AW-1:0]        mnt_addr,
    output logic                 mnt_ack,
    input  logic                 snp_valid,
    input  logic [AW-1:0]        snp_addr,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_addr,
    output logic [DW-1:0]        mem_wdata,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 mem_ack
);
    localparam int TAG_W = AW - IDX_W;
    localparam int NL    = 1 << IDX_W;

    typedef struct packed {
        st_e             st;
        logic [AW-1:0]   addr;
        logic [DW-1:0]   wdata;
        logic            we;
        logic            is_mnt;
        logic [1:0]      op;
        logic            kill;
        logic [DW-1:0]   rdata;
        logic            cpu_ack;
        logic            mnt_ack;
        logic            mem_req;
        logic            mem_we;
        logic [AW-1:0]   mem_addr;
        logic [DW-1:0]   mem_wdata;
    } state_t;

    state_t d, q;

    logic [AW-1:0]    cur_addr;
    logic [IDX_W-1:0] cur_idx, s_idx;
    logic [TAG_W-1:0] cur_tag, s_tag;
    pol_e             cur_pol, s_pol;
    logic             ra_valid, ra_dirty, rb_valid;
    logic [TAG_W-1:0] ra_tag, rb_tag;
    logic [DW-1:0]    ra_data;
    logic             hit, victim_dirty, snp_wt;
    logic             wr_en, wr_valid, wr_dirty, clr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [TAG_W-1:0] wr_tag;
    logic [DW-1:0]    wr_data;
    logic [NL-1:0]    valid_vec, dirty_vec;

    assign cur_addr = (q.st == ST_IDLE) ? (mnt_req ? mnt_addr : cpu_addr) : q.addr;
    assign cur_idx  = cur_addr[IDX_W-1:0];
    assign cur_tag  = cur_addr[AW-1:IDX_W];
    assign s_idx    = snp_addr[IDX_W-1:0];
    assign s_tag    = snp_addr[AW-1:IDX_W];

    coh_region_map #(.AW(AW), .RB(RB)) req_map_i (
        .addr(cur_addr), .pol_tbl(region_pol), .pol(cur_pol)
    );
    coh_region_map #(.AW(AW), .RB(RB)) snp_map_i (
        .addr(snp_addr), .pol_tbl(region_pol), .pol(s_pol)
    );

    coh_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DW(DW)) store_i (
        .clk(clk), .rst(rst),
        .ra_idx(cur_idx), .ra_valid(ra_valid), .ra_dirty(ra_dirty),
        .ra_tag(ra_tag), .ra_data(ra_data),
        .rb_idx(s_idx), .rb_valid(rb_valid), .rb_tag(rb_tag),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_dirty(wr_dirty),
        .clr_en(clr_en), .clr_idx(s_idx),
        .valid_vec(valid_vec), .dirty_vec(dirty_vec)
    );

    assign hit          = ra_valid && (ra_tag == cur_tag);
    assign victim_dirty = ra_valid && ra_dirty;
    assign snp_wt       = snp_valid && (s_pol == POL_WTHRU);

    always_comb begin
        d         = q;
        d.cpu_ack = 1'b0;
        d.mnt_ack = 1'b0;
        wr_en     = 1'b0;
        wr_idx    = cur_idx;
        wr_tag    = ra_tag;
        wr_data   = ra_data;
        wr_valid  = ra_valid;
        wr_dirty  = ra_dirty;

        case (q.st)
            ST_IDLE: begin
                d.kill = 1'b0;
                if (mnt_req) begin
                    d.addr   = mnt_addr;
                    d.is_mnt = 1'b1;
                    d.op     = mnt_op;
                    if (hit && ra_dirty && (mnt_op & OP_CLEAN_BIT) != 2'b00) begin
                        d.mem_req   = 1'b1;
                        d.mem_we    = 1'b1;
                        d.mem_addr  = mnt_addr;
                        d.mem_wdata = ra_data;
                        d.st        = ST_WBACK;
                    end else begin
                        if (hit && (mnt_op & OP_INVAL_BIT) != 2'b00) begin
                            wr_en    = 1'b1;
                            wr_valid = 1'b0;
                            wr_dirty = 1'b0;
                        end
                        d.mnt_ack = 1'b1;
                        d.st      = ST_DONE;
                    end
                end else if (cpu_req) begin
                    d.addr   = cpu_addr;
                    d.we     = cpu_we;
                    d.wdata  = cpu_wdata;
                    d.is_mnt = 1'b0;
                    if (cur_pol == POL_UNCACHED || cur_pol == POL_UNC_ALT) begin
                        d.mem_req   = 1'b1;
                        d.mem_we    = cpu_we;
                        d.mem_addr  = cpu_addr;
                        d.mem_wdata = cpu_wdata;
                        d.st        = cpu_we ? ST_MWR : ST_NCRD;
                    end else if (cpu_we && cur_pol == POL_WTHRU) begin
                        if (hit) begin
                            wr_en    = 1'b1;
                            wr_data  = cpu_wdata;
                            wr_valid = 1'b1;
                            wr_dirty = 1'b0;
                        end
                        d.mem_req   = 1'b1;
                        d.mem_we    = 1'b1;
                        d.mem_addr  = cpu_addr;
                        d.mem_wdata = cpu_wdata;
                        d.st        = ST_MWR;
                    end else if (cpu_we) begin
                        if (hit || !victim_dirty) begin
                            wr_en     = 1'b1;
                            wr_tag    = cur_tag;
                            wr_data   = cpu_wdata;
                            wr_valid  = 1'b1;
                            wr_dirty  = 1'b1;
                            d.cpu_ack = 1'b1;
                            d.st      = ST_DONE;
                        end else begin
                            d.mem_req   = 1'b1;
                            d.mem_we    = 1'b1;
                            d.mem_addr  = {ra_tag, cur_idx};
                            d.mem_wdata = ra_data;
                            d.st        = ST_WBACK;
                        end
                    end else if (hit) begin
                        d.rdata   = ra_data;
                        d.cpu_ack = 1'b1;
                        d.st      = ST_DONE;
                    end else if (victim_dirty) begin
                        d.mem_req   = 1'b1;
                        d.mem_we    = 1'b1;
                        d.mem_addr  = {ra_tag, cur_idx};
                        d.mem_wdata = ra_data;
                        d.st        = ST_WBACK;
                    end else begin
                        d.mem_req  = 1'b1;
                        d.mem_we   = 1'b0;
                        d.mem_addr = cpu_addr;
                        d.st       = ST_FILL;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_ack) begin
                    d.mem_req = 1'b0;
                    if (q.is_mnt) begin
                        wr_en     = 1'b1;
                        wr_valid  = (q.op & OP_INVAL_BIT) == 2'b00;
                        wr_dirty  = 1'b0;
                        d.mnt_ack = 1'b1;
                        d.st      = ST_DONE;
                    end else if (q.we) begin
                        wr_en     = 1'b1;
                        wr_tag    = cur_tag;
                        wr_data   = q.wdata;
                        wr_valid  = 1'b1;
                        wr_dirty  = 1'b1;
                        d.cpu_ack = 1'b1;
                        d.st      = ST_DONE;
                    end else begin
                        d.mem_req  = 1'b1;
                        d.mem_we   = 1'b0;
                        d.mem_addr = q.addr;
                        d.st       = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                if (snp_wt && s_idx == cur_idx) begin
                    d.kill = 1'b1;
                end
                if (mem_ack) begin
                    d.mem_req = 1'b0;
                    wr_en     = 1'b1;
                    wr_tag    = cur_tag;
                    wr_data   = mem_rdata;
                    wr_valid  = !q.kill;
                    wr_dirty  = 1'b0;
                    d.rdata   = mem_rdata;
                    d.cpu_ack = 1'b1;
                    d.st      = ST_DONE;
                end
            end
            ST_MWR: begin
                if (mem_ack) begin
                    d.mem_req = 1'b0;
                    d.cpu_ack = 1'b1;
                    d.st      = ST_DONE;
                end
            end
            ST_NCRD: begin
                if (mem_ack) begin
                    d.mem_req = 1'b0;
                    d.rdata   = mem_rdata;
                    d.cpu_ack = 1'b1;
                    d.st      = ST_DONE;
                end
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase

        // a snoop colliding with an array write at the same index wins
        if (wr_en && snp_wt && s_idx == wr_idx &&
            (s_tag == wr_tag || q.st == ST_FILL)) begin
            wr_valid = 1'b0;
            wr_dirty = 1'b0;
        end
        clr_en = snp_wt && rb_valid && (rb_tag == s_tag) &&
                 !(wr_en && wr_idx == s_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign cpu_ack   = q.cpu_ack;
    assign cpu_rdata = q.rdata;
    assign mnt_ack   = q.mnt_ack;
    assign mem_req   = q.mem_req;
    assign mem_we    = q.mem_we;
    assign mem_addr  = q.mem_addr;
    assign mem_wdata = q.mem_wdata;
endmodule

// File: rtl/coh_dcache_chk.sv
module coh_dcache_chk #(
    parameter int IDX_W = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cpu_ack,
    input logic                  mnt_ack,
    input logic                  mem_req,
    input logic                  mem_ack,
    input logic                  snp_clr,
    input logic [IDX_W-1:0]      snp_idx,
    input logic [(1<<IDX_W)-1:0] valid_vec,
    input logic [(1<<IDX_W)-1:0] dirty_vec
);
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (valid_vec == '0 && !mem_req && !cpu_ack)); // R1

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> mem_req); // R5

    AST_SNOOP_DROPS: assert property (@(posedge clk) disable iff (rst)
        snp_clr |=> !valid_vec[$past(snp_idx)]); // R7

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
        (dirty_vec & ~valid_vec) == '0); // R10

    AST_ACK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cpu_ack, mnt_ack})); // R13

    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (rst)
        cpu_ack |=> !cpu_ack); // R13
endmodule

bind coh_dcache coh_dcache_chk #(.IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst(rst), .cpu_ack(cpu_ack), .mnt_ack(mnt_ack),
    .mem_req(mem_req), .mem_ack(mem_ack), .snp_clr(clr_en),
    .snp_idx(s_idx), .valid_vec(valid_vec), .dirty_vec(dirty_vec)
);

// File: tb/coh_dcache_tb_top.sv
`timescale 1ns/1ps
module coh_dcache_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  region_pol = {2'b01, 2'b10, 2'b01, 2'b00};
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        mnt_req = 1'b0;
    logic [1:0]  mnt_op = '0;
    logic [7:0]  mnt_addr = '0;
    logic        mnt_ack;
    logic        snp_valid = 1'b0;
    logic [7:0]  snp_addr = '0;
    logic        mem_req, mem_we;
    logic [7:0]  mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    logic [31:0] mem [256];
    int          lat = 1, cnt = 0, rd_cnt = 0, wr_cnt = 0;
    int          checks = 0, errors = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    coh_dcache dut_i (
        .clk(clk), .rst(rst), .region_pol(region_pol),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .mnt_req(mnt_req), .mnt_op(mnt_op), .mnt_addr(mnt_addr), .mnt_ack(mnt_ack),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    always @(posedge clk) begin
        if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (cnt >= lat - 1) begin
                cnt     <= 0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_cnt        <= wr_cnt + 1;
                end else begin
                    mem_rdata <= mem[mem_addr];
                    rd_cnt    <= rd_cnt + 1;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ack);
        rd = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic mnt_cmd(input logic [1:0] op, input logic [7:0] a);
        @(negedge clk);
        mnt_req = 1'b1; mnt_op = op; mnt_addr = a;
        do @(negedge clk); while (!mnt_ack);
        mnt_req = 1'b0;
    endtask

    task automatic ext_write(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        mem[a] = v; snp_valid = 1'b1; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic summary;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            summary();
        end
    end

    initial begin
        logic [31:0] rd;
        int r0, w0, mnt_t, cpu_t, cyc;
        for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 | i;
        repeat (4) @(negedge clk);
        chk(!cpu_ack && !mnt_ack && !mem_req, "R1", {29'd0, cpu_ack, mnt_ack, mem_req}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(!cpu_ack && !mnt_ack && !mem_req, "R1", {29'd0, cpu_ack, mnt_ack, mem_req}, 32'h0);

        // R2 sweep of the uncached region
        for (int i = 0; i < 16; i++) begin
            r0 = rd_cnt;
            cpu_op(1'b0, 8'(i), '0, rd);
            chk(rd == (32'hA000_0000 | i), "R2", rd, 32'hA000_0000 | i);
            cpu_op(1'b0, 8'(i), '0, rd);
            chk(rd_cnt == r0 + 2, "R2", rd_cnt, r0 + 2);
        end
        w0 = wr_cnt;
        cpu_op(1'b1, 8'd5, 32'h1234_5678, rd);
        chk(wr_cnt == w0 + 1 && mem[5] == 32'h1234_5678, "R2", mem[5], 32'h1234_5678);

        // R5 / R1 fill the write-through region, then hit
        for (int i = 0; i < 8; i++) begin
            r0 = rd_cnt;
            cpu_op(1'b0, 8'(64 + i), '0, rd);
            chk(rd == (32'hA000_0040 | i) && rd_cnt == r0 + 1, "R1", rd, 32'hA000_0040 | i);
        end
        for (int i = 0; i < 8; i++) begin
            r0 = rd_cnt;
            cpu_op(1'b0, 8'(64 + i), '0, rd);
            chk(rd == (32'hA000_0040 | i) && rd_cnt == r0, "R5", rd, 32'hA000_0040 | i);
        end

        // R3 write-through hits and a non-allocating miss
        for (int i = 0; i < 4; i++) begin
            w0 = wr_cnt; r0 = rd_cnt;
            cpu_op(1'b1, 8'(64 + i), 32'h7700_0000 + i, rd);
            chk(wr_cnt == w0 + 1 && mem[64 + i] == 32'h7700_0000 + i, "R3", mem[64 + i], 32'h7700_0000 + i);
            cpu_op(1'b0, 8'(64 + i), '0, rd);
            chk(rd == 32'h7700_0000 + i && rd_cnt == r0, "R3", rd, 32'h7700_0000 + i);
        end
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1'b1, 8'd72, 32'hCAFE_0072, rd);
        cpu_op(1'b0, 8'd64, '0, rd);
        chk(wr_cnt == w0 + 1 && rd == 32'h7700_0000 && rd_cnt == r0, "R3", rd, 32'h7700_0000);

        // R7 snoop on write-through line
        ext_write(8'd65, 32'hE0E0_0065);
        r0 = rd_cnt;
        cpu_op(1'b0, 8'd65, '0, rd);
        chk(rd == 32'hE0E0_0065 && rd_cnt == r0 + 1, "R7", rd, 32'hE0E0_0065);

        // R4 / R8 write-back line ignores snoops
        cpu_op(1'b0, 8'd130, '0, rd);
        w0 = wr_cnt;
        cpu_op(1'b1, 8'd130, 32'hB0B0_0130, rd);
        chk(wr_cnt == w0 && mem[130] == 32'hA000_0082, "R4", mem[130], 32'hA000_0082);
        ext_write(8'd130, 32'hEEEE_0130);
        r0 = rd_cnt;
        cpu_op(1'b0, 8'd130, '0, rd);
        chk(rd == 32'hB0B0_0130 && rd_cnt == r0, "R8", rd, 32'hB0B0_0130);

        // R9 clean
        w0 = wr_cnt;
        mnt_cmd(2'b01, 8'd130);
        chk(wr_cnt == w0 + 1 && mem[130] == 32'hB0B0_0130, "R9", mem[130], 32'hB0B0_0130);
        r0 = rd_cnt;
        cpu_op(1'b0, 8'd130, '0, rd);
        chk(rd == 32'hB0B0_0130 && rd_cnt == r0, "R9", rd, 32'hB0B0_0130);
        w0 = wr_cnt;
        mnt_cmd(2'b01, 8'd130);
        chk(wr_cnt == w0, "R9", wr_cnt, w0);

        // R10 invalidate discards dirty data
        w0 = wr_cnt;
        cpu_op(1'b1, 8'd131, 32'hD1D1_0131, rd);
        mnt_cmd(2'b10, 8'd131);
        r0 = rd_cnt;
        cpu_op(1'b0, 8'd131, '0, rd);
        chk(wr_cnt == w0 && rd == 32'hA000_0083 && rd_cnt == r0 + 1, "R10", rd, 32'hA000_0083);

        // R11 clean plus invalidate
        cpu_op(1'b1, 8'd132, 32'hC2C2_0132, rd);
        w0 = wr_cnt;
        mnt_cmd(2'b11, 8'd132);
        chk(wr_cnt == w0 + 1 && mem[132] == 32'hC2C2_0132, "R11", mem[132], 32'hC2C2_0132);
        r0 = rd_cnt;
        cpu_op(1'b0, 8'd132, '0, rd);
        chk(rd == 32'hC2C2_0132 && rd_cnt == r0 + 1, "R11", rd, 32'hC2C2_0132);

        // R6 dirty victim written back before fill
        cpu_op(1'b1, 8'd133, 32'h9999_0133, rd);
        w0 = wr_cnt; r0 = rd_cnt;
        cpu_op(1'b0, 8'd69, '0, rd);
        chk(wr_cnt == w0 + 1 && mem[133] == 32'h9999_0133, "R6", mem[133], 32'h9999_0133);
        chk(rd == 32'hA000_0045 && rd_cnt == r0 + 1, "R6", rd, 32'hA000_0045);

        // R12 snoop collides with a fill at the same index
        lat = 4;
        r0 = rd_cnt;
        fork
            cpu_op(1'b0, 8'd78, '0, rd);
            begin
                do @(negedge clk); while (!(mem_req && !mem_we));
                snp_valid = 1'b1; snp_addr = 8'd70;
                @(negedge clk);
                snp_valid = 1'b0;
            end
        join
        chk(rd == 32'hA000_004E && rd_cnt == r0 + 1, "R12", rd, 32'hA000_004E);
        cpu_op(1'b0, 8'd78, '0, rd);
        chk(rd_cnt == r0 + 2, "R12", rd_cnt, r0 + 2);
        cpu_op(1'b0, 8'd78, '0, rd);
        chk(rd_cnt == r0 + 2, "R12", rd_cnt, r0 + 2);
        lat = 1;

        // R4 / R9 sweep over every index of the write-back region
        for (int i = 0; i < 8; i++) begin
            cpu_op(1'b1, 8'(144 + i), 32'h5000_0000 + i * 257, rd);
            chk(mem[144 + i] == (32'hA000_0090 | i), "R4", mem[144 + i], 32'hA000_0090 | i);
        end
        for (int i = 0; i < 8; i++) begin
            mnt_cmd(2'b01, 8'(144 + i));
            chk(mem[144 + i] == 32'h5000_0000 + i * 257, "R9", mem[144 + i], 32'h5000_0000 + i * 257);
        end

        // R13 maintenance served ahead of a simultaneous CPU request
        @(negedge clk);
        r0 = rd_cnt;
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'd144;
        mnt_req = 1'b1; mnt_op = 2'b10; mnt_addr = 8'd144;
        mnt_t = -1; cpu_t = -1; cyc = 0;
        while (cpu_t < 0 && cyc < 50) begin
            @(negedge clk);
            cyc++;
            if (mnt_ack) begin mnt_t = cyc; mnt_req = 1'b0; end
            if (cpu_ack) begin cpu_t = cyc; rd = cpu_rdata; cpu_req = 1'b0; end
        end
        chk(mnt_t > 0 && cpu_t > mnt_t, "R13", cpu_t, mnt_t + 1);
        chk(rd_cnt == r0 + 1 && rd == 32'h5000_0000, "R13", rd, 32'h5000_0000);

        finished = 1;
        summary();
    end
endmodule